// File: doc/BRIEF.md
# Triggered PWM Timer with Input Noise Filters

This block is a 16-bit up-counter that paces three pulse-width outputs. A period register closes each counting cycle. A mode bit picks what happens when the counter reaches the period value: it either wraps to zero and keeps going, or it parks there until something restarts it. Each of the three outputs has its own compare register and its own active level. An output sits in its active state while the count is below its compare value. It sits in its inactive state from the compare value up to the end of the period.

A counting run starts in one of two ways. Software can write a start bit. An edge on an external trigger pin can also start it, and the pin responds to rising edges, falling edges, both, or neither. Either start clears the counter to zero and sets it running.

Four general input pins and the trigger pin each pass through a two-flop synchronizer. Each of the five can then be routed through a noise filter, which changes its output only after three equal samples in a row. The samples are taken on a sampling clock chosen from several rates. The filtered levels of the four general pins are brought out so that other logic can use them. A plain synchronous register port, with a write strobe and a combinational read mux, configures the block.

Top module: `trg_pwm_timer`

## Requirements
- R1: After reset every configuration register is 0.
  - The control word (address 0) reads 0x0080 and the filter word (address 1) reads 0x0000.
  - The count (address 6) reads 0.
  - All PWM outputs are high: inactive at the default active-low level.
  - The filtered pin levels are 0.
- R2: Writing the control word with bit 6 set clears the counter to 0 on that clock edge. The counter then increments by one on every following clock while running.
- R3: With the stop bit (control bit 3) at 0, the counter moves from the period value (address 2) back to 0 on the next clock and keeps counting.
- R4: With the stop bit at 1, the counter stays at the period value once it reaches it, until a software start or a trigger start.
- R5: Each output n (B, C, D at bit 0, 1, 2 of `pwm_out`, with compare registers at addresses 3, 4, 5) is active while count < compare and inactive otherwise.
- R6: Control bits 0, 1 and 2 set the level of outputs B, C and D. A 1 makes the output high when active, and a 0 makes it low when active. The inactive level is the complement.
- R7: Control bits 5:4 select the trigger edge.
  - The codes are: 00 trigger ignored, 01 rising edge, 10 falling edge, 11 both edges.
  - A selected edge clears the counter to 0 and sets it running.
  - Unfiltered, the counter reads 0 three clocks after the pin changes.
- R8: With a pin's filter bit at 0, that pin bypasses the filter. Its level appears two clocks after the pin changes.
- R9: Filter word bits 3:0 enable the filter on pins A to D.
  - An enabled filter changes its output only after three consecutive equal samples.
  - At the full sampling rate a level held for three clocks appears five clocks after the pin change.
  - A two-clock pulse never appears.
- R10: Filter word bits 6:5 select the sampling rate: 00 every 32nd clock, 01 every 8th clock, 10 every clock, 11 the count source (every clock).
- R11: Filter word bit 4 filters the trigger pin, which takes effect only when the edge field is nonzero. A filtered trigger pulse shorter than three samples starts nothing.
- R12: Unused positions read as constants and ignore writes.
  - Control bit 7 reads 1.
  - Control bits 6 and 15:8 read 0.
  - Filter bits 15:7 read 0.
  - Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the count source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| pin_in | input | 4 | Raw input pins A..D (bit 0 = A) |
| trg_in | input | 1 | Raw trigger pin |
| pwm_out | output | 3 | PWM outputs B, C, D (bit 0 = B) |
| pin_filt | output | 4 | Synchronized and optionally filtered pins A..D |

## Verification
A wrong counter state shows at the ports within a clock. It appears both on the count read and on the PWM outputs, because every output is a pure comparison against the count. A wrong run or stop flag shows up as a count that keeps moving past the period or freezes early, and the period-length checks catch it. A filter whose sample history is off by one lets a level through one sample early or late, and the checks at the exact fourth and fifth clock see it. The same checks catch a dropped two-clock pulse that should not have appeared. A bad edge-detector history restarts the counter on the wrong edge, which is visible as a count of 0 instead of the parked period value.

// File: rtl/trg_pwm_pkg.sv
package trg_pwm_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_FILT = 3'd1,
    A_PER  = 3'd2,
    A_CMPB = 3'd3,
    A_CMPC = 3'd4,
    A_CMPD = 3'd5,
    A_CNT  = 3'd6,
    A_NONE = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_e;

  typedef enum logic [1:0] {
    FCLK_SLOW = 2'd0,
    FCLK_FAST = 2'd1,
    FCLK_FULL = 2'd2,
    FCLK_CNT  = 2'd3
  } fclk_e;
endpackage

// File: rtl/trg_pwm_tick.sv
module trg_pwm_tick #(
  parameter int unsigned SLOW = 32,
  parameter int unsigned FAST = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  trg_pwm_pkg::fclk_e    sel,
  output logic                  tick
);
  import trg_pwm_pkg::*;
  localparam int unsigned SW = $clog2(SLOW);
  localparam int unsigned FW = $clog2(FAST);

  logic [SW-1:0] div_q, div_d;
  logic          tick_slow, tick_fast;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;

  assign tick_slow = &div_q;
  assign tick_fast = &div_q[FW-1:0];

  always_comb begin
    unique case (sel)
      FCLK_SLOW: tick = tick_slow;
      FCLK_FAST: tick = tick_fast;
      default:   tick = 1'b1;
    endcase
  end

  AST_SLOW_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_slow |=> !tick_slow); // R10
endmodule

// File: rtl/trg_pwm_infilt.sv
module trg_pwm_infilt #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic tick,
  input  logic filt_en,
  output logic lvl
);
  logic              s1_q, s2_q;
  logic [STAGES-1:0] sh_q, sh_d;
  logic              f_q, f_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_raw;
      s2_q <= s1_q;
    end

  always_comb begin
    sh_d = sh_q;
    f_d  = f_q;
    if (tick) begin
      sh_d = {sh_q[STAGES-2:0], s2_q};
      if (&sh_d)       f_d = 1'b1;
      else if (~|sh_d) f_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q <= '0;
      f_q  <= 1'b0;
    end else begin
      sh_q <= sh_d;
      f_q  <= f_d;
    end

  assign lvl = filt_en ? f_q : s2_q;

  AST_FILT_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(f_q) |-> $past(tick)); // R9
  AST_FILT_RISE_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_q) |-> $past(s2_q)); // R9
endmodule

// File: rtl/trg_pwm_core.sv
module trg_pwm_core #(
  parameter int unsigned CW  = 16,
  parameter int unsigned NCH = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    stop_mode,
  input  logic [CW-1:0]           period,
  input  logic [NCH-1:0][CW-1:0]  cmp,
  input  logic [NCH-1:0]          pol,
  output logic [CW-1:0]           cnt_o,
  output logic [NCH-1:0]          pwm_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (start) begin
      cnt_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == period) begin
        if (stop_mode) run_d = 1'b0;
        else           cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign pwm_o[ch] = (cnt_q < cmp[ch]) ? pol[ch] : ~pol[ch];
  end

  assign cnt_o = cnt_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0 && run_q)); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start && cnt_q != period) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start && !stop_mode && cnt_q == period) |=> cnt_q == '0); // R3
  AST_PARK_AT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start && stop_mode && cnt_q == period) |=> !run_q); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/trg_pwm_timer.sv
module trg_pwm_timer #(
  parameter int unsigned DW      = 16,
  parameter int unsigned NPIN    = 4,
  parameter int unsigned DIV_LO  = 32,
  parameter int unsigned DIV_HI  = 8,
  parameter int unsigned FSTAGES = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NPIN-1:0] pin_in,
  input  logic            trg_in,
  output logic [2:0]      pwm_out,
  output logic [NPIN-1:0] pin_filt
);
  import trg_pwm_pkg::*;
  localparam int unsigned NCH  = 3;
  localparam int unsigned NFLT = NPIN + 1;

  logic [NCH-1:0]          pol_q, pol_d;
  logic                    stop_q, stop_d;
  edge_e                   edge_q, edge_d;
  logic [NFLT-1:0]         fen_q, fen_d;
  fclk_e                   fsel_q, fsel_d;
  logic [DW-1:0]           per_q, per_d;
  logic [NCH-1:0][DW-1:0]  cmp_q, cmp_d;
  logic                    go_wr;
  logic                    samp_tick;
  logic [NFLT-1:0]         raw_vec, lvl_vec, en_vec;
  logic                    trg_lvl, trg_prev_q, trg_rise, trg_fall, trig_hit;
  logic [DW-1:0]           cnt;

  always_comb begin
    pol_d  = pol_q;
    stop_d = stop_q;
    edge_d = edge_q;
    fen_d  = fen_q;
    fsel_d = fsel_q;
    per_d  = per_q;
    cmp_d  = cmp_q;
    if (reg_we) begin
      unique case (reg_addr)
        A_CTRL: begin
          pol_d  = reg_wdata[NCH-1:0];
          stop_d = reg_wdata[3];
          edge_d = edge_e'(reg_wdata[5:4]);
        end
        A_FILT: begin
          fen_d  = reg_wdata[NFLT-1:0];
          fsel_d = fclk_e'(reg_wdata[6:5]);
        end
        A_PER:  per_d    = reg_wdata;
        A_CMPB: cmp_d[0] = reg_wdata;
        A_CMPC: cmp_d[1] = reg_wdata;
        A_CMPD: cmp_d[2] = reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pol_q  <= '0;
      stop_q <= 1'b0;
      edge_q <= EDGE_OFF;
      fen_q  <= '0;
      fsel_q <= FCLK_SLOW;
      per_q  <= '0;
      cmp_q  <= '0;
    end else begin
      pol_q  <= pol_d;
      stop_q <= stop_d;
      edge_q <= edge_d;
      fen_q  <= fen_d;
      fsel_q <= fsel_d;
      per_q  <= per_d;
      cmp_q  <= cmp_d;
    end

  assign go_wr = reg_we && (reg_addr == A_CTRL) && reg_wdata[6];

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[NCH-1:0] = pol_q;
        reg_rdata[3]       = stop_q;
        reg_rdata[5:4]     = edge_q;
        reg_rdata[7]       = 1'b1;
      end
      A_FILT: begin
        reg_rdata[NFLT-1:0] = fen_q;
        reg_rdata[6:5]      = fsel_q;
      end
      A_PER:   reg_rdata = per_q;
      A_CMPB:  reg_rdata = cmp_q[0];
      A_CMPC:  reg_rdata = cmp_q[1];
      A_CMPD:  reg_rdata = cmp_q[2];
      A_CNT:   reg_rdata = cnt;
      default: reg_rdata = '0;
    endcase
  end

  trg_pwm_tick #(.SLOW(DIV_LO), .FAST(DIV_HI)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (fsel_q),
    .tick (samp_tick)
  );

  assign raw_vec = {trg_in, pin_in};
  assign en_vec  = {fen_q[NFLT-1] && (edge_q != EDGE_OFF), fen_q[NFLT-2:0]};

  for (genvar p = 0; p < NFLT; p++) begin : g_flt
    trg_pwm_infilt #(.STAGES(FSTAGES)) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_raw(raw_vec[p]),
      .tick   (samp_tick),
      .filt_en(en_vec[p]),
      .lvl    (lvl_vec[p])
    );
  end

  assign pin_filt = lvl_vec[NPIN-1:0];
  assign trg_lvl  = lvl_vec[NFLT-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trg_prev_q <= 1'b0;
    else        trg_prev_q <= trg_lvl;

  assign trg_rise = trg_lvl & ~trg_prev_q;
  assign trg_fall = ~trg_lvl & trg_prev_q;

  always_comb begin
    unique case (edge_q)
      EDGE_RISE: trig_hit = trg_rise;
      EDGE_FALL: trig_hit = trg_fall;
      EDGE_BOTH: trig_hit = trg_rise | trg_fall;
      default:   trig_hit = 1'b0;
    endcase
  end

  trg_pwm_core #(.CW(DW), .NCH(NCH)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (go_wr | trig_hit),
    .stop_mode(stop_q),
    .period   (per_q),
    .cmp      (cmp_q),
    .pol      (pol_q),
    .cnt_o    (cnt),
    .pwm_o    (pwm_out)
  );

  AST_TRIG_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> cnt == '0); // R7
  AST_CTRL_CONST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> reg_rdata[7] && !reg_rdata[6]); // R12
endmodule

// File: tb/trg_pwm_timer_test.sv
module trg_pwm_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [3:0]  pin_in;
  logic        trg_in;
  logic [2:0]  pwm_out;
  logic [3:0]  pin_filt;

  int total = 0;
  int bad   = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  trg_pwm_timer uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .trg_in(trg_in), .pwm_out(pwm_out), .pin_filt(pin_filt)
  );

  // period, cmpB, polB, stop, clocks after start, expected count, expected pwm B
  localparam int VEC [8][7] = '{
    '{9,  3, 1, 0,  2, 2, 1},
    '{9,  3, 1, 0,  3, 3, 0},
    '{9,  3, 0, 0, 12, 2, 0},
    '{9,  3, 0, 1, 12, 9, 1},
    '{4,  0, 1, 0,  1, 1, 0},
    '{4,  5, 1, 1, 20, 4, 1},
    '{0,  1, 1, 0,  7, 0, 1},
    '{15, 8, 1, 0, 16, 0, 1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trig_case(input logic [1:0] ed, input bit hit_r, input bit hit_f, input string req);
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'd5);
    wr(3'd0, 16'h0048 | (16'(ed) << 4));
    settle(8);
    rd(3'd6, rv); chk({req, " parked R4"}, rv, 5);
    trg_in = 1'b1;
    settle(3);
    rd(3'd6, rv); chk({req, " rise"}, rv, hit_r ? 0 : 5);
    settle(2);
    rd(3'd6, rv); chk({req, " rise+2"}, rv, hit_r ? 2 : 5);
    settle(6);
    trg_in = 1'b0;
    settle(3);
    rd(3'd6, rv); chk({req, " fall"}, rv, hit_f ? 0 : 5);
    settle(2);
    rd(3'd6, rv); chk({req, " fall+2"}, rv, hit_f ? 2 : 5);
    settle(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
    pin_in = '0; trg_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, rv); chk("R1 ctrl", rv, 16'h0080);
    rd(3'd1, rv); chk("R1 filt", rv, 16'h0000);
    rd(3'd6, rv); chk("R1 count", rv, 0);
    chk("R1 pwm", pwm_out, 3'b111);
    chk("R1 pin_filt", pin_filt, 4'h0);

    // R2 R3 R4 R5 R6 vector walk
    for (int i = 0; i < 8; i++) begin
      wr(3'd2, 16'(VEC[i][0]));
      wr(3'd3, 16'(VEC[i][1]));
      wr(3'd0, 16'(VEC[i][2]) | 16'(VEC[i][3] << 3) | 16'h0040);
      settle(VEC[i][4]);
      rd(3'd6, rv); chk($sformatf("R2 R3 R4 count row %0d", i), rv, VEC[i][5]);
      chk($sformatf("R5 R6 pwm B row %0d", i), pwm_out[0], VEC[i][6]);
    end

    // R5 R6 outputs C and D with mixed levels
    wr(3'd2, 16'd9); wr(3'd3, 16'd8); wr(3'd4, 16'd5); wr(3'd5, 16'd2);
    wr(3'd0, 16'h0042);
    settle(3);
    chk("R5 R6 pwm B C D", pwm_out, 3'b110);

    // R12 fixed bits
    wr(3'd0, 16'hFF00);
    rd(3'd0, rv); chk("R12 ctrl upper ignored", rv, 16'h0080);
    wr(3'd0, 16'hFFBF);
    rd(3'd0, rv); chk("R12 ctrl fields", rv, 16'h00BF);
    wr(3'd1, 16'hFFFF);
    rd(3'd1, rv); chk("R12 filt fields", rv, 16'h007F);
    rd(3'd7, rv); chk("R12 empty address", rv, 0);
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);
    wr(3'd3, 16'd0); wr(3'd4, 16'd0); wr(3'd5, 16'd0);

    // R7 edge selection
    trig_case(2'b00, 0, 0, "R7 off");
    trig_case(2'b01, 1, 0, "R7 rise");
    trig_case(2'b10, 0, 1, "R7 fall");
    trig_case(2'b11, 1, 1, "R7 both");

    // R8 bypass latency
    wr(3'd1, 16'h0000);
    @(negedge clk) pin_in[1] = 1'b1;
    settle(1); chk("R8 bypass early", pin_filt[1], 0);
    settle(1); chk("R8 bypass late", pin_filt[1], 1);
    pin_in[1] = 1'b0; settle(4);

    // R9 three-sample filter at full rate
    wr(3'd1, 16'h0041);
    @(negedge clk) pin_in[0] = 1'b1;
    settle(4); chk("R9 not yet", pin_filt[0], 0);
    settle(1); chk("R9 passes", pin_filt[0], 1);
    pin_in[0] = 1'b0; settle(8);
    chk("R9 back low", pin_filt[0], 0);
    pin_in[0] = 1'b1; settle(2); pin_in[0] = 1'b0;
    seen = 0;
    for (int k = 0; k < 10; k++) begin settle(1); if (pin_filt[0]) seen = 1; end
    chk("R9 short pulse dropped", seen, 0);

    // R10 sampling rates on pin B
    wr(3'd1, 16'h0022);
    @(negedge clk) pin_in[1] = 1'b1; settle(10); pin_in[1] = 1'b0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin settle(1); if (pin_filt[1]) seen = 1; end
    chk("R10 div8 drops 10", seen, 0);
    pin_in[1] = 1'b1; settle(40); chk("R10 div8 passes 40", pin_filt[1], 1);
    pin_in[1] = 1'b0; settle(40);
    wr(3'd1, 16'h0002);
    @(negedge clk) pin_in[1] = 1'b1; settle(40); pin_in[1] = 1'b0;
    seen = 0;
    for (int k = 0; k < 10; k++) begin settle(1); if (pin_filt[1]) seen = 1; end
    chk("R10 div32 drops 40", seen, 0);
    pin_in[1] = 1'b1; settle(120); chk("R10 div32 passes 120", pin_filt[1], 1);
    wr(3'd1, 16'h0062);
    @(negedge clk) pin_in[1] = 1'b0;
    settle(4); chk("R10 count source not yet", pin_filt[1], 1);
    settle(1); chk("R10 count source passes", pin_filt[1], 0);

    // R11 filtered trigger
    wr(3'd1, 16'h0050);
    wr(3'd2, 16'd5);
    wr(3'd0, 16'h0058);
    settle(8);
    trg_in = 1'b1; settle(2); trg_in = 1'b0;
    settle(10);
    rd(3'd6, rv); chk("R11 short trigger ignored", rv, 5);
    trg_in = 1'b1; settle(10);
    rd(3'd6, rv); chk("R11 filtered trigger starts", rv, 4);
    trg_in = 1'b0; settle(8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule